// File: doc/BRIEF.md
# Interrupt Request Mapping Controller

This block collects level-sensitive interrupt request lines from up to 32 peripheral sources and folds them into one 32-bit pending vector for a single receiving processor. A small configuration table gives each source its own entry: an enable flag and the number of the vector bit that the source should raise. A source whose enable flag is clear is ignored. Several sources may share one vector bit, in which case their requests are ORed. A vector bit that no enabled source targets stays at zero.

The routing path does not rank requests. All enabled, active sources show up in the vector in the same cycle. A separate priority stage looks at the registered vector and reports the lowest-numbered pending bit together with a valid flag. The receiver can use this result when more than one bit is pending at once. The table is written and read through a plain address/data register port, one entry per source.

Top module: `irq_map_ctrl`

## Requirements
- R1: While reset is asserted at a clock edge, every table entry returns to zero (source ignored). After that edge `irq_vec` is zero and `irq_valid` is low.
- R2: A write with `cfg_we` high at a clock edge stores `cfg_wdata` into the entry selected by `cfg_addr`. Bit 5 of an entry is the enable flag and bits 4:0 are the target vector bit. `cfg_rdata` always shows the entry selected by `cfg_addr`.
- R3: When an enabled source has its request high at a clock edge, the vector bit named by its entry is set in `irq_vec` after that edge.
- R4: A source whose enable flag is 0 has no effect on `irq_vec`, whatever its request does.
- R5: A vector bit that no enabled, active source targets reads as zero.
- R6: When several enabled sources target the same bit, that bit is set while any one of them is requesting.
- R7: Requests are levels. A vector bit clears at the first edge at which none of its sources is requesting, and no acknowledge is needed.
- R8: `irq_valid` is high exactly when `irq_vec` is nonzero. `irq_idx` is then the index of the lowest-numbered set bit of `irq_vec`.
- R9: Requests that are active together are all reflected in `irq_vec` in the same cycle. The routing path applies no priority.
- R10: A table write is used for routing from the next edge onward. The edge that performs the write still routes with the old entry.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 32 | Level interrupt requests, one per source |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 5 | Source number of the entry to write or read |
| cfg_wdata | input | 6 | Entry to write: bit 5 enable, bits 4:0 target bit |
| cfg_rdata | output | 6 | Entry currently selected by `cfg_addr` |
| irq_vec | output | 32 | Registered pending vector toward the receiver |
| irq_idx | output | 5 | Lowest-numbered pending bit |
| irq_valid | output | 1 | At least one vector bit is pending |

## Verification
The assertions assume that the request lines are already synchronous to `clk` and stable around each rising edge. They also assume that `cfg_addr` names an existing source whenever `cfg_we` is high. The stimulus changes requests and configuration only on falling edges and addresses only sources 0 to 31. Under those conditions the properties can compare the vector and the table directly with the values sampled one edge earlier.

// File: rtl/irq_map_pkg.sv
// Package: irq_map_pkg
// Shared widths and the configuration entry type for the IRQ mapping controller.
// Assumes the receiver vector width is a power of two.
package irq_map_pkg;
    localparam int unsigned VEC_W = 32;
    localparam int unsigned TGT_W = $clog2(VEC_W);
    localparam int unsigned ENT_W = TGT_W + 1;

    typedef struct packed {
        logic             en;
        logic [TGT_W-1:0] tgt;
    } map_entry_t;
endpackage

// File: rtl/irq_map_table.sv
// Module: irq_map_table
// Holds one routing entry per source. Writes are synchronous and reads are
// combinational. Assumes cfg_addr < NUM_SRC whenever cfg_we is high.
module irq_map_table
    import irq_map_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SRC_W-1:0]          cfg_addr,
    input  logic [ENT_W-1:0]          cfg_wdata,
    output logic [ENT_W-1:0]          cfg_rdata,
    output map_entry_t [NUM_SRC-1:0]  tbl
);
    // Store entries; reset leaves every source ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl <= '0;
        end else if (cfg_we) begin
            tbl[cfg_addr] <= map_entry_t'(cfg_wdata);
        end
    end

    // Present the addressed entry on the read port.
    always_comb begin
        cfg_rdata = tbl[cfg_addr];
    end

    // R2: a write lands in the addressed entry at the next edge.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (tbl[$past(cfg_addr)] == map_entry_t'($past(cfg_wdata))));
endmodule

// File: rtl/irq_route.sv
// Module: irq_route
// Combinational routing matrix. Each enabled source drives its target bit,
// and sources that share a bit are ORed. No priority is applied here.
module irq_route
    import irq_map_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]        src_req,
    input  map_entry_t [NUM_SRC-1:0]  tbl,
    output logic [VEC_W-1:0]          vec_next
);
    // hit[b][s] is high when source s is active, enabled and aimed at bit b.
    logic [NUM_SRC-1:0] hit [VEC_W];

    for (genvar b = 0; b < VEC_W; b++) begin : g_bit
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign hit[b][s] = src_req[s] && tbl[s].en &&
                               (tbl[s].tgt == TGT_W'(b));
        end
        assign vec_next[b] = |hit[b];
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Reports the lowest-numbered set bit of the pending vector and a valid flag.
// The clock and reset are used only by the checks.
module irq_prio_enc
    import irq_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  vec,
    output logic [TGT_W-1:0]  idx,
    output logic              valid
);
    // Scan from the top so that the lowest set bit is the one kept.
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = VEC_W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = TGT_W'(i);
                valid = 1'b1;
            end
        end
    end

    // R8: the reported bit is set in the vector.
    a_r8_idx_is_set: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> vec[idx]);
    // R8: no lower bit is pending.
    a_r8_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((vec & ((VEC_W'(1) << idx) - VEC_W'(1))) == '0));
    // R8: an empty vector reports no request.
    a_r8_empty_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (vec == '0) |-> !valid);
endmodule

// File: rtl/irq_map_ctrl.sv
// Module: irq_map_ctrl
// Top level. Routes per-source level requests through the mapping table into
// a registered pending vector and encodes the lowest pending bit.
// Assumes src_req is already synchronous to clk.
module irq_map_ctrl
    import irq_map_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               cfg_we,
    input  logic [SRC_W-1:0]   cfg_addr,
    input  logic [ENT_W-1:0]   cfg_wdata,
    output logic [ENT_W-1:0]   cfg_rdata,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [TGT_W-1:0]   irq_idx,
    output logic               irq_valid
);
    map_entry_t [NUM_SRC-1:0] tbl;
    logic [VEC_W-1:0]         vec_next;
    logic [NUM_SRC-1:0]       en_mask;

    irq_map_table #(.NUM_SRC(NUM_SRC)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tbl       (tbl)
    );

    irq_route #(.NUM_SRC(NUM_SRC)) route_i (
        .src_req  (src_req),
        .tbl      (tbl),
        .vec_next (vec_next)
    );

    // Register the routed vector toward the receiver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_vec <= '0;
        end else begin
            irq_vec <= vec_next;
        end
    end

    irq_prio_enc prio_i (
        .clk   (clk),
        .rst_n (rst_n),
        .vec   (irq_vec),
        .idx   (irq_idx),
        .valid (irq_valid)
    );

    // Collect enable flags for the checks below.
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            en_mask[s] = tbl[s].en;
        end
    end

    // R1: reset empties the vector.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (irq_vec == '0 && !irq_valid));
    // R4: with every source ignored, nothing becomes pending.
    a_r4_ignored_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |=> (irq_vec == '0));
    // R7: with no request active, the vector empties at the next edge.
    a_r7_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0) |=> (irq_vec == '0));
    // R5: the vector can hold a bit only if some enabled source was active.
    a_r5_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_req & en_mask) == '0) |=> (irq_vec == '0));
endmodule

// File: tb/irq_map_ctrl_tb.sv
// Testbench for irq_map_ctrl. A vector table covers routing, then directed
// tests cover reset, the read port, reconfiguration timing and reset mid-run.
module irq_map_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [5:0]  cfg_wdata = '0;
    logic [5:0]  cfg_rdata;
    logic [31:0] irq_vec;
    logic [4:0]  irq_idx;
    logic        irq_valid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_map_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_vec(irq_vec), .irq_idx(irq_idx), .irq_valid(irq_valid)
    );

    // Stimulus request pattern and expected vector under the mapping below:
    // src0->bit5, src1->bit5, src2->bit0, src3->bit31, src31->bit17,
    // src4 aimed at bit9 but disabled, every other source ignored.
    localparam int NV = 11;
    localparam logic [63:0] VECS [NV] = '{
        {32'h0000_0001, 32'h0000_0020},
        {32'h0000_0002, 32'h0000_0020},
        {32'h0000_0003, 32'h0000_0020},
        {32'h0000_0004, 32'h0000_0001},
        {32'h0000_0008, 32'h8000_0000},
        {32'h0000_0010, 32'h0000_0000},
        {32'h8000_0000, 32'h0002_0000},
        {32'h8000_000F, 32'h8002_0021},
        {32'hFFFF_FFE0, 32'h0002_0000},
        {32'h0000_0000, 32'h0000_0000},
        {32'h0000_000C, 32'h8000_0001}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_prio(input string req, input logic [31:0] v);
        logic [4:0] e_idx = '0;
        logic       e_val = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) begin
                e_idx = 5'(i);
                e_val = 1'b1;
            end
        end
        check(req, {31'b0, irq_valid}, {31'b0, e_val});
        if (e_val) check(req, {27'b0, irq_idx}, {27'b0, e_idx});
    endtask

    task automatic cfg_write(input int src, input logic en, input int bitn);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 5'(src);
        cfg_wdata = {en, 5'(bitn)};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 vec", irq_vec, 32'h0);
        check("R1 valid", {31'b0, irq_valid}, 32'h0);
        rst_n = 1'b1;

        // R4 (reset part): with the table empty, requests do nothing.
        src_req = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        check("R4 empty table", irq_vec, 32'h0);
        src_req = '0;

        cfg_write(0, 1'b1, 5);
        cfg_write(1, 1'b1, 5);
        cfg_write(2, 1'b1, 0);
        cfg_write(3, 1'b1, 31);
        cfg_write(4, 1'b0, 9);
        cfg_write(31, 1'b1, 17);

        // R2: read port, enable in bit 5 and target in bits 4:0.
        cfg_addr = 5'd3; #1;
        check("R2 readback src3", {26'b0, cfg_rdata}, 32'h3F);
        cfg_addr = 5'd4; #1;
        check("R2 readback src4", {26'b0, cfg_rdata}, 32'h09);

        // R3 R4 R5 R6 R7 R9 R8: vector table walk.
        foreach (VECS[k]) begin
            @(negedge clk);
            src_req = VECS[k][63:32];
            @(posedge clk); @(negedge clk);
            check("R3/R4/R5/R6/R7/R9 vec", irq_vec, VECS[k][31:0]);
            check_prio("R8 prio", VECS[k][31:0]);
        end

        // R10: remap src2 from bit 0 to bit 12 while it is held high.
        src_req = 32'h0000_0004;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'd2; cfg_wdata = {1'b1, 5'd12};
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        check("R10 write edge uses old entry", irq_vec, 32'h0000_0001);
        @(posedge clk); @(negedge clk);
        check("R10 new entry applies", irq_vec, 32'h0000_1000);
        check_prio("R8 after remap", 32'h0000_1000);

        // R7: release the request; bit clears with no acknowledge.
        src_req = '0;
        @(posedge clk); @(negedge clk);
        check("R7 clear", irq_vec, 32'h0);
        check("R8 idle valid", {31'b0, irq_valid}, 32'h0);

        // R1: reset mid-run clears the vector and the table.
        src_req = 32'h8000_0008;
        @(posedge clk); @(negedge clk);
        check("R1 pre-reset vec", irq_vec, 32'h8002_0000);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid-run vec", irq_vec, 32'h0);
        cfg_addr = 5'd31; #1;
        check("R1 table cleared", {26'b0, cfg_rdata}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R1 after reset ignored", irq_vec, 32'h0);
        src_req = '0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule